// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

This block gathers interrupt requests from sixteen peripheral lines arranged as two eight-line priority units, resolves which pending request has the highest priority, and signals the processor on one interrupt output. The secondary unit hangs off line 2 of the primary unit, so fifteen sources are usable. A request wired to the old cascade position, line 2, is handled exactly as if it had arrived on secondary line 9.

When the processor acknowledges, the winning source enters service and its vector appears on the vector bus for one cycle. The vector is a base value supplied by the unit that owns the source, with the 3-bit line number below it. An in-service record permits nesting: a more urgent request may interrupt a handler that is running, while equal or less urgent ones wait. An end-of-interrupt strobe retires the most urgent handler that is in service.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset `intr_o` and `vec_valid_o` are 0, `vec_o` is all zeros and no source is in service.
- R2: Request lines are level inputs sampled on each rising clock edge. With nothing in service, `intr_o` is 1 in the cycle after the edge that samples any request, and 0 in the cycle after the edge that samples no request.
- R3: Priority, from highest to lowest: line 0, line 1, secondary lines 8 to 15 in ascending order (the rank of primary line 2), then lines 3 to 7 in ascending order.
- R4: When `ack_i` is 1 at an edge where `intr_o` is 1, the highest-priority pending source enters service and in the next cycle `vec_valid_o` is 1 with its vector. `vec_valid_o` lasts one cycle and `vec_o` is all zeros whenever `vec_valid_o` is 0.
- R5: The vector of primary line n (n = 0,1,3..7) is `{pri_base_i, n[2:0]}`; the vector of secondary line 8+k is `{sec_base_i, k[2:0]}`.
- R6: A request on line 2 acts as a request on line 9: it takes line 9's priority and produces vector `{sec_base_i, 3'd1}`.
- R7: `intr_o` is 1 only while some pending request ranks strictly above the highest-priority source in service; equal or lower requests wait.
- R8: An `eoi_i` pulse removes only the highest-priority source in service; less urgent nested sources stay in service.
- R9: `ack_i` at an edge where `intr_o` is 0 has no effect: no vector is produced and no source enters service.
- R10: When `ack_i` and `eoi_i` coincide, the end of interrupt removes the source that was in service before the edge and the new winner enters service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 16 | Request levels; 0..7 primary, 8..15 secondary, 2 rerouted to 9 |
| pri_base_i | input | VEC_W-3 | Vector base of the primary unit |
| sec_base_i | input | VEC_W-3 | Vector base of the secondary unit |
| ack_i | input | 1 | Interrupt acknowledge from the processor |
| eoi_i | input | 1 | End-of-interrupt strobe |
| intr_o | output | 1 | Interrupt request to the processor |
| vec_valid_o | output | 1 | Vector bus carries a vector this cycle |
| vec_o | output | VEC_W | Vector of the acknowledged source |

## Verification
The bench drives single requests on primary and secondary lines, mixed requests spanning both units so the secondary group's placement between lines 1 and 3 is tested, and a request on line 2 alone and against line 8 to tell rerouting from plain primary handling. Nested sequences add lower and then higher requests under a running handler, which separates strict-priority preemption from equal or lower waiting. An acknowledge with no interrupt pending and an acknowledge coinciding with an end of interrupt show, through later interrupt behaviour, whether the in-service record was touched. A behavioural model is compared with the outputs on every clock alongside hand-computed checks.

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      irq_req_i,
  input  logic [VEC_W-4:0] pri_base_i,
  input  logic [VEC_W-4:0] sec_base_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             intr_o,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o
);
  localparam int NSRC  = 16;
  localparam int NRANK = 15;
  localparam int LINK  = 2;
  localparam int REMAP = 9;
  localparam logic [3:0] NONE = 4'(NRANK);

  // rank -> source: 0,1 primary; 2..9 secondary 8..15; 10..14 primary 3..7
  function automatic logic [3:0] src_of(input int r);
    if (r < LINK)           return 4'(r);
    else if (r < LINK + 8)  return 4'(r + 6);
    else                    return 4'(r - 7);
  endfunction

  logic [NSRC-1:0]  req_q, isr_q, req_map;
  logic [NRANK-1:0] req_rk, isr_rk;
  logic [3:0]       req_top, isr_top, win_src, clr_src;
  logic [NSRC-1:0]  set_mask, clr_mask;
  logic [VEC_W-1:0] vec_new;
  logic             take;

  always_comb begin
    req_map        = irq_req_i;
    req_map[REMAP] = irq_req_i[REMAP] | irq_req_i[LINK];
    req_map[LINK]  = 1'b0;
  end

  for (genvar r = 0; r < NRANK; r++) begin : g_rank
    assign req_rk[r] = req_q[src_of(r)];
    assign isr_rk[r] = isr_q[src_of(r)];
  end

  always_comb begin
    req_top = NONE;
    isr_top = NONE;
    for (int r = NRANK - 1; r >= 0; r--) begin
      if (req_rk[r]) req_top = 4'(r);
      if (isr_rk[r]) isr_top = 4'(r);
    end
  end

  assign intr_o   = req_top < isr_top;
  assign take     = ack_i & intr_o;
  assign win_src  = src_of(int'(req_top));
  assign clr_src  = src_of(int'(isr_top));
  assign set_mask = take ? (NSRC'(1) << win_src) : '0;
  assign clr_mask = (eoi_i && isr_top != NONE) ? (NSRC'(1) << clr_src) : '0;
  assign vec_new  = win_src[3] ? {sec_base_i, win_src[2:0]} : {pri_base_i, win_src[2:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q       <= '0;
      isr_q       <= '0;
      vec_valid_o <= 1'b0;
      vec_o       <= '0;
    end else begin
      req_q       <= req_map;
      isr_q       <= (isr_q & ~clr_mask) | set_mask;
      vec_valid_o <= take;
      vec_o       <= take ? vec_new : '0;
    end
  end
endmodule

// File: rtl/cascade_irq_sva.sv
module cascade_irq_sva #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ack_i,
  input logic             eoi_i,
  input logic             intr_o,
  input logic             vec_valid_o,
  input logic [VEC_W-1:0] vec_o,
  input logic [15:0]      isr
);
  AST_ACK_GIVES_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && intr_o |=> vec_valid_o); // R4
  AST_NO_STRAY_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_i && intr_o) |=> !vec_valid_o); // R9
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid_o |-> vec_o == '0); // R4
  AST_ONE_ENTRY_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(isr & ~$past(isr)) <= 1); // R4
  AST_ENTRY_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ack_i) |-> (isr & ~$past(isr)) == '0); // R9
  AST_ONE_EXIT_PER_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    $countones($past(isr) & ~isr) <= 1); // R8
  AST_EXIT_NEEDS_EOI: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(eoi_i) |-> ($past(isr) & ~isr) == '0); // R8
  AST_LINK_NEVER_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    !isr[2]); // R6
endmodule

bind cascade_irq_ctrl cascade_irq_sva #(.VEC_W(VEC_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .ack_i(ack_i), .eoi_i(eoi_i), .intr_o(intr_o),
  .vec_valid_o(vec_valid_o), .vec_o(vec_o), .isr(isr_q)
);

// File: tb/test_cascade_irq_ctrl.sv
module test_cascade_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int VEC_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, ack = 1'b0, eoi = 1'b0;
  logic [15:0] req = '0;
  logic [VEC_W-4:0] pbase = 5'h08, sbase = 5'h0E;
  logic intr, vvalid;
  logic [VEC_W-1:0] vec;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cascade_irq_ctrl #(.VEC_W(VEC_W)) i_cascade_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_req_i(req), .pri_base_i(pbase), .sec_base_i(sbase),
    .ack_i(ack), .eoi_i(eoi), .intr_o(intr), .vec_valid_o(vvalid), .vec_o(vec));

  // reference model
  int prio [16];
  bit m_req [16];
  bit m_isr [16];
  bit m_valid;
  logic [VEC_W-1:0] m_vec;

  initial begin
    prio[0] = 0; prio[1] = 1; prio[2] = 99;
    for (int i = 3; i < 8; i++)  prio[i] = i + 7;
    for (int i = 8; i < 16; i++) prio[i] = i - 6;
  end

  function automatic int best_req();
    int b = 15;
    for (int i = 0; i < 16; i++) if (m_req[i] && prio[i] < b) b = prio[i];
    return b;
  endfunction
  function automatic int top_isr();
    int b = 15;
    for (int i = 0; i < 16; i++) if (m_isr[i] && prio[i] < b) b = prio[i];
    return b;
  endfunction
  function automatic int src_with(int p);
    for (int i = 0; i < 16; i++) if (prio[i] == p) return i;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_req[i] = 0; m_isr[i] = 0; end
      m_valid = 0; m_vec = '0;
    end else begin
      int b, t, w;
      b = best_req(); t = top_isr();
      if (eoi && t < 15) m_isr[src_with(t)] = 0;
      if (ack && b < t) begin
        w = src_with(b);
        m_isr[w] = 1; m_valid = 1;
        m_vec = (w >= 8) ? {sbase, 3'(w - 8)} : {pbase, 3'(w)};
      end else begin
        m_valid = 0; m_vec = '0;
      end
      for (int i = 0; i < 16; i++) m_req[i] = req[i];
      m_req[9] = req[9] | req[2];
      m_req[2] = 0;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R7 model intr", 32'(intr), 32'(best_req() < top_isr()));
    chk("R4 model valid", 32'(vvalid), 32'(m_valid));
    chk("R5 model vector", 32'(vec), 32'(m_vec));
  end

  task automatic step(); @(negedge clk); endtask
  task automatic pulse_ack(); ack = 1; step(); ack = 0; endtask
  task automatic pulse_eoi(); eoi = 1; step(); eoi = 0; endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    chk("R1 intr after reset", 32'(intr), 0);
    chk("R1 valid after reset", 32'(vvalid), 0);
    chk("R1 vector after reset", 32'(vec), 0);

    req = 16'h0020; step();
    chk("R2 request raises intr", 32'(intr), 1);
    pulse_ack();
    chk("R4 vector valid", 32'(vvalid), 1);
    chk("R5 primary vector", 32'(vec), 32'h45);
    step();
    chk("R4 valid one cycle", 32'(vvalid), 0);
    chk("R4 idle bus zero", 32'(vec), 0);
    chk("R7 same level waits", 32'(intr), 0);
    req = 16'h0060; step();
    chk("R7 lower waits", 32'(intr), 0);
    req = 16'h0068; step();
    chk("R7 higher nests", 32'(intr), 1);
    pulse_ack();
    chk("R5 nested vector", 32'(vec), 32'h43);
    req = 16'h0060; pulse_eoi();
    chk("R8 outer handler still blocks", 32'(intr), 0);
    pulse_eoi();
    chk("R8 level request returns", 32'(intr), 1);
    req = 16'h0000; step(); step();
    chk("R2 no request no intr", 32'(intr), 0);

    req = 16'h1088; step();
    pulse_ack();
    chk("R3 secondary beats line 3", 32'(vec), 32'h74);
    req = 16'h0088; pulse_eoi();
    pulse_ack();
    chk("R3 line 3 beats line 7", 32'(vec), 32'h43);
    req = 16'h0000; pulse_eoi(); step();
    chk("R3 all retired", 32'(intr), 0);

    req = 16'h0004; step();
    chk("R6 line 2 interrupts", 32'(intr), 1);
    pulse_ack();
    chk("R6 rerouted vector", 32'(vec), 32'h71);
    req = 16'h0104; step();
    chk("R6 line 8 outranks rerouted 2", 32'(intr), 1);
    pulse_ack();
    chk("R6 line 8 vector", 32'(vec), 32'h70);
    req = 16'h0000; pulse_eoi(); pulse_eoi(); step();
    chk("R6 retired", 32'(intr), 0);

    pulse_ack();
    chk("R9 ack without intr no vector", 32'(vvalid), 0);
    req = 16'h0020; step(); pulse_ack();
    req = 16'h0060; step();
    chk("R9 intr low before stray ack", 32'(intr), 0);
    pulse_ack();
    chk("R9 stray ack no vector", 32'(vvalid), 0);
    req = 16'h0040; pulse_eoi();
    chk("R9 line 6 never entered service", 32'(intr), 1);
    req = 16'h0000; step();

    req = 16'h0020; step(); pulse_ack();
    req = 16'h0002; step();
    chk("R10 line 1 pending", 32'(intr), 1);
    ack = 1; eoi = 1; step(); ack = 0; eoi = 0;
    chk("R10 coincident vector", 32'(vec), 32'h41);
    req = 16'h0000; pulse_eoi();
    req = 16'h0040; step();
    chk("R10 line 5 was retired", 32'(intr), 1);
    req = 16'h0000; step(); step();

    finish_run();
  end
endmodule